// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This block shifts one integer element by a signed count carried with the element. When the count is negative the element moves right by the count's magnitude. When the count is zero or positive the element moves left. Half-up rounding of right shifts is optional, and so is saturation of left shifts that overflow. Three interpretations of the element are available: signed in and signed out, unsigned in and unsigned out, and signed in with unsigned out. The element width can be 8, 16, 32 or 64 bits. It sits in the low bits of a 64-bit operand.

The datapath is combinational and feeds a single output register that has a valid/ready handshake. Each accepted operation returns its result and a per-result saturation flag one cycle later. Every saturation event is also ORed into a sticky status bit. That bit stays set until the clear input is raised.

Top module: `qshift_unit`

## Requirements
- R1: The count is the low byte of `in_cnt`, read as a two's-complement value from -128 to +127. Upper bits of `in_cnt` are ignored. A negative count shifts right by its magnitude. A count of 0 up to width-1 shifts left.
- R2: `in_wsel` selects the width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Only the low width bits of `in_src` are used. `out_data` holds the element in its low bits. Above the element it is sign-extended in signed-out mode and zero-filled in the other modes.
- R3: With rounding on, a right shift by n rounds half upward. The result is floor((x + 2^(n-1)) / 2^n). With rounding off it truncates toward minus infinity.
- R4: In signed mode (`in_mode` 0), a right shift by the width or more gives 0 when rounding is on. When rounding is off it gives every bit equal to the sign bit.
- R5: In unsigned modes, a right shift by more than the width gives 0. A shift by exactly the width also gives 0 when rounding is off. With rounding on it gives the element's top bit.
- R6: A left shift with a count below the width overflows when the true product cannot be represented at the width. With saturation on, an overflow saturates and sets `out_sat`.
- R7: A left shift with a count of the width or more gives 0 when the input is zero or saturation is off. Otherwise the result saturates and `out_sat` is set.
- R8: A signed saturated result is the most positive value for a non-negative input and the most negative value for a negative input. An unsigned saturated result is all ones at the width.
- R9: `in_mode` 2 is signed-to-unsigned. With saturation on, an input whose top element bit is 1 gives 0 and sets `out_sat`. Otherwise the element is taken as an unsigned bit pattern and follows the unsigned rules. `in_mode` 1 and 3 are both unsigned.
- R10: With saturation off, an overflowing left shift keeps the low width bits, formatted as in R2. `out_sat` stays 0.
- R11: `in_ready` is high when the output register is empty or `out_ready` is high. An element accepted on one clock edge shows on `out_data`/`out_sat` with `out_valid` high after that edge. The output is held while `out_ready` is low.
- R12: `sat_sticky` is set by any accepted operation that saturates. It is cleared by `sat_clr`. If a set and a clear arrive in the same cycle, the set wins. Otherwise the bit holds.
- R13: After reset, `out_valid`, `out_sat` and `sat_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_src | input | 64 | Element operand, low bits used |
| in_cnt | input | CNT_W (16) | Count operand, low byte used |
| in_wsel | input | 2 | Element width select |
| in_mode | input | 2 | 0 signed, 1/3 unsigned, 2 signed-to-unsigned |
| in_rnd | input | 1 | Rounding enable for right shifts |
| in_sat | input | 1 | Saturation enable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_data | output | 64 | Shifted element, formatted per R2 |
| out_sat | output | 1 | This result saturated |
| sat_clr | input | 1 | Clear the sticky flag |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
Some properties are checked on every cycle. The output register must hold steady under back-pressure. The sticky bit must follow its set, clear and hold rules. A signed-to-unsigned negative clamp must appear as zero with the flag raised. Saturation must never be flagged when it is disabled, and must always be flagged when an overflow is accepted with it enabled. The actual numeric results need the bench's scenarios, since those compare them against an independent model. The scenarios include rounding direction, sign fill versus zero for full-width right shifts, the top-bit case of unsigned rounding, clamp values per width, wrap formatting and the set-versus-clear collision.

// File: rtl/qs_pkg.sv
package qs_pkg;
  localparam int XW = 64;
  localparam int EW = 2 * XW + 2;

  typedef enum logic [1:0] {
    QS_SS  = 2'd0,
    QS_UU  = 2'd1,
    QS_SU  = 2'd2,
    QS_UU2 = 2'd3
  } qs_mode_e;

  typedef struct packed {
    logic [XW-1:0] res;
    logic          sat;
    logic          ovf;
    logic          clamp;
    logic          right;
  } qs_out_t;

  function automatic logic [XW-1:0] qs_mask(input logic [1:0] wsel);
    logic [XW-1:0] m;
    case (wsel)
      2'd0:    m = {{(XW-8){1'b0}}, 8'hFF};
      2'd1:    m = {{(XW-16){1'b0}}, 16'hFFFF};
      2'd2:    m = {{(XW-32){1'b0}}, 32'hFFFF_FFFF};
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic int qs_bits(input logic [1:0] wsel);
    return 8 << wsel;
  endfunction

  // Wide signed container: every right-shift corner case falls out of >>>.
  function automatic qs_out_t qs_eval(input logic [XW-1:0] src,
                                      input logic signed [7:0] cnt,
                                      input logic [1:0] wsel,
                                      input qs_mode_e mode,
                                      input logic rnd,
                                      input logic sat);
    qs_out_t o;
    logic [XW-1:0] m;
    logic [XW-1:0] top;
    logic [XW-1:0] el;
    logic topbit, sgn, neg_out;
    logic signed [EW-1:0] v, t, t2, val, ext, rr;
    int bits, mag, sh;
    m      = qs_mask(wsel);
    bits   = qs_bits(wsel);
    top    = m ^ (m >> 1);
    topbit = |(src & top);
    sgn    = (mode == QS_SS);
    v      = {{(EW-XW){1'b0}}, src & m};
    if (sgn && topbit) v = v | ~{{(EW-XW){1'b0}}, m};
    o       = '0;
    o.clamp = (mode == QS_SU) && sat && topbit;
    rr      = '0;
    if (cnt < 0) begin
      o.right = 1'b1;
      mag     = -int'(cnt);
      if (rnd) begin
        t  = v >>> (mag - 1);
        t2 = t >>> 1;
        rr = t2 + {{(EW-1){1'b0}}, t[0]};
      end else begin
        rr = v >>> mag;
      end
    end else begin
      sh = int'(cnt);
      if (sh < bits) begin
        val = v <<< sh;
        ext = {{(EW-XW){1'b0}}, val[XW-1:0] & m};
        if (sgn && |(val[XW-1:0] & top)) ext = ext | ~{{(EW-XW){1'b0}}, m};
        o.ovf = (ext != val);
        rr    = val;
      end else begin
        o.ovf = (v != '0);
        rr    = '0;
      end
    end
    if (o.clamp) begin
      o.sat = 1'b1;
      o.res = '0;
    end else if (o.ovf && sat) begin
      o.sat = 1'b1;
      if (sgn) o.res = topbit ? ~(m >> 1) : (m >> 1);
      else     o.res = m;
    end else begin
      o.res = rr[XW-1:0];
    end
    el      = o.res & m;
    neg_out = |(el & top);
    o.res   = (sgn && neg_out) ? (el | ~m) : el;
    return o;
  endfunction
endpackage

// File: rtl/qs_core.sv
module qs_core
  import qs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [XW-1:0]    src,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       wsel,
  input  logic [1:0]       mode,
  input  logic             rnd,
  input  logic             sat,
  output qs_out_t          res
);
  logic signed [7:0] cnt_lo;
  assign cnt_lo = $signed(cnt[7:0]);
  always_comb begin
    res = qs_eval(src, cnt_lo, wsel, qs_mode_e'(mode), rnd, sat);
  end
endmodule

// File: rtl/qs_stage.sv
module qs_stage #(
  parameter int W = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/qs_sticky.sv
module qs_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/qshift_unit.sv
module qshift_unit
  import qs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XW-1:0]    in_src,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [1:0]       in_wsel,
  input  logic [1:0]       in_mode,
  input  logic             in_rnd,
  input  logic             in_sat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XW-1:0]    out_data,
  output logic             out_sat,
  input  logic             sat_clr,
  output logic             sat_sticky
);
  localparam int PAY_W = XW + 1;

  qs_out_t          core_o;
  logic             acc;
  logic             ev_sat, ev_ovf, ev_clamp, ev_right;
  logic [PAY_W-1:0] pay_q;

  qs_core #(.CNT_W(CNT_W)) u_core (
    .src(in_src), .cnt(in_cnt), .wsel(in_wsel), .mode(in_mode),
    .rnd(in_rnd), .sat(in_sat), .res(core_o)
  );

  assign ev_sat   = core_o.sat;
  assign ev_ovf   = core_o.ovf;
  assign ev_clamp = core_o.clamp;
  assign ev_right = core_o.right;
  assign acc      = in_valid && in_ready;

  qs_stage #(.W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d({core_o.sat, core_o.res}), .out_valid(out_valid),
    .out_ready(out_ready), .q(pay_q)
  );

  assign out_data = pay_q[XW-1:0];
  assign out_sat  = pay_q[XW];

  qs_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set(acc && ev_sat), .clr(sat_clr),
    .flag(sat_sticky)
  );
endmodule

// File: rtl/qshift_unit_chk.sv
module qshift_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc,
  input logic        ev_sat,
  input logic        ev_ovf,
  input logic        ev_clamp,
  input logic        in_sat,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_sat,
  input logic        sat_clr,
  input logic        sat_sticky
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sat));
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  a_r12_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_sat |=> sat_sticky);
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !(acc && ev_sat) |=> !sat_sticky);
  a_r12_keep: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clr |=> sat_sticky);
  a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_clamp |=> out_data == 64'd0 && out_sat);
  a_r10_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_sat |=> !out_sat);
  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_ovf && in_sat |=> out_sat);
endmodule

bind qshift_unit qshift_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .ev_sat(ev_sat), .ev_ovf(ev_ovf),
  .ev_clamp(ev_clamp), .in_sat(in_sat), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sat(out_sat),
  .sat_clr(sat_clr), .sat_sticky(sat_sticky)
);

// File: tb/qshift_unit_bench.sv
module qshift_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [15:0] in_cnt = '0;
  logic [1:0]  in_wsel = '0;
  logic [1:0]  in_mode = '0;
  logic        in_rnd = 1'b0;
  logic        in_sat = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_sat;
  logic        sat_clr = 1'b0;
  logic        sat_sticky;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qshift_unit u_qshift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_cnt(in_cnt), .in_wsel(in_wsel), .in_mode(in_mode),
    .in_rnd(in_rnd), .in_sat(in_sat), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sat(out_sat),
    .sat_clr(sat_clr), .sat_sticky(sat_sticky)
  );

  task automatic chk(input string tag, input logic [64:0] got, input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Independent model built from the requirement text: range tests, add-half rounding.
  function automatic logic [64:0] model(input logic [63:0] src, input logic [15:0] cnt,
                                        input logic [1:0] wsel, input logic [1:0] mode,
                                        input logic rnd, input logic sat);
    logic signed [139:0] one, x, p, r, lim;
    logic [63:0] mk, lo, ro;
    logic neg, is_s, over, fl;
    int w, k, n;
    w    = 8 << wsel;
    k    = int'($signed(cnt[7:0]));
    mk   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    lo   = src & mk;
    neg  = lo[w-1];
    is_s = (mode == 2'd0);
    one  = 140'sd1;
    if (mode == 2'd2 && sat && neg) return {1'b1, 64'd0};
    x = '0;
    x[63:0] = lo;
    if (is_s && neg) x = x - (one <<< w);
    over = 1'b0;
    fl   = 1'b0;
    r    = '0;
    if (k < 0) begin
      n = -k;
      if (is_s && n >= w)                        r = (rnd || !neg) ? '0 : -one;
      else if (!is_s && (n > w || (n == w && !rnd))) r = '0;
      else if (rnd)                              r = (x + (one <<< (n - 1))) >>> n;
      else                                       r = x >>> n;
    end else if (k >= w) begin
      over = (x != 0);
    end else begin
      p = x <<< k;
      if (is_s) begin
        lim  = one <<< (w - 1);
        over = (p > lim - one) || (p < -lim);
      end else begin
        over = (p >= (one <<< w));
      end
      r = p;
    end
    if (over && sat) begin
      fl = 1'b1;
      if (is_s) r = neg ? -(one <<< (w - 1)) : (one <<< (w - 1)) - one;
      else      r = (one <<< w) - one;
    end
    ro = r[63:0] & mk;
    if (is_s && ro[w-1]) ro = ro | ~mk;
    return {fl, ro};
  endfunction

  // One operation through the handshake; result sampled at the following negedge.
  task automatic op(input string tag, input logic [63:0] src, input logic [15:0] cnt,
                    input logic [1:0] wsel, input logic [1:0] mode, input logic rnd,
                    input logic sat, input logic [64:0] exp);
    @(negedge clk);
    in_src = src; in_cnt = cnt; in_wsel = wsel; in_mode = mode;
    in_rnd = rnd; in_sat = sat; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {64'd0, out_valid}, 65'd1);
    chk(tag, {out_sat, out_data}, exp);
  endtask

  task automatic t_reset;
    chk("R13 out_valid", {64'd0, out_valid}, 65'd0);
    chk("R13 out_sat", {64'd0, out_sat}, 65'd0);
    chk("R13 sticky", {64'd0, sat_sticky}, 65'd0);
  endtask

  task automatic t_count_and_width;
    op("R1 low byte -1 of 16'h12FF", 64'h8, 16'h12FF, 2'd0, 2'd1, 1'b0, 1'b0, {1'b0, 64'h4});
    op("R2 upper src bits ignored", 64'hABCD_0000_0000_0005, 16'd1, 2'd0, 2'd1, 1'b0, 1'b0, {1'b0, 64'h0A});
    op("R2 signed sign-extension 16b", 64'h0000_0000_0000_8000, 16'hFFFF, 2'd1, 2'd0, 1'b0, 1'b0,
       {1'b0, 64'hFFFF_FFFF_FFFF_C000});
    op("R1 left by width-1 32b", 64'h1, 16'd31, 2'd2, 2'd1, 1'b0, 1'b0, {1'b0, 64'h8000_0000});
  endtask

  task automatic t_round;
    op("R3 -3 >>1 round", 64'hFD, 16'hFFFF, 2'd0, 2'd0, 1'b1, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    op("R3 5 >>1 round", 64'h5, 16'hFFFF, 2'd0, 2'd1, 1'b1, 1'b0, {1'b0, 64'h3});
    op("R3 5 >>1 trunc", 64'h5, 16'hFFFF, 2'd0, 2'd1, 1'b0, 1'b0, {1'b0, 64'h2});
    op("R3 -5 >>2 trunc", 64'hFB, 16'hFFFE, 2'd0, 2'd0, 1'b0, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFE});
    op("R3 64b max >>1 round", 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 2'd3, 2'd1, 1'b1, 1'b0,
       {1'b0, 64'h8000_0000_0000_0000});
  endtask

  task automatic t_full_right;
    op("R4 signed >>8 no round", 64'h80, 16'hFFF8, 2'd0, 2'd0, 1'b0, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    op("R4 signed >>8 round", 64'h80, 16'hFFF8, 2'd0, 2'd0, 1'b1, 1'b0, {1'b0, 64'h0});
    op("R4 signed >>100 no round", 64'h8000_0000, 16'h009C, 2'd2, 2'd0, 1'b0, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    op("R5 unsigned >>8 round top bit", 64'h80, 16'hFFF8, 2'd0, 2'd1, 1'b1, 1'b0, {1'b0, 64'h1});
    op("R5 unsigned >>8 no round", 64'h80, 16'hFFF8, 2'd0, 2'd1, 1'b0, 1'b0, {1'b0, 64'h0});
    op("R5 unsigned >>9 round", 64'hFF, 16'hFFF7, 2'd0, 2'd1, 1'b1, 1'b0, {1'b0, 64'h0});
    op("R5 unsigned >>64 round 64b", 64'h8000_0000_0000_0000, 16'hFFC0, 2'd3, 2'd1, 1'b1, 1'b0, {1'b0, 64'h1});
  endtask

  task automatic t_left_sat;
    op("R6 R8 signed 0x40<<1 sat", 64'h40, 16'd1, 2'd0, 2'd0, 1'b0, 1'b1, {1'b1, 64'h7F});
    op("R6 R8 signed -0x41<<1 sat", 64'hBF, 16'd1, 2'd0, 2'd0, 1'b0, 1'b1, {1'b1, 64'hFFFF_FFFF_FFFF_FF80});
    op("R6 signed -0x40<<1 fits", 64'hC0, 16'd1, 2'd0, 2'd0, 1'b0, 1'b1, {1'b0, 64'hFFFF_FFFF_FFFF_FF80});
    op("R6 R8 unsigned 0x80<<1 sat", 64'h80, 16'd1, 2'd0, 2'd1, 1'b0, 1'b1, {1'b1, 64'hFF});
    op("R6 R8 64b signed sat", 64'h4000_0000_0000_0000, 16'd1, 2'd3, 2'd0, 1'b0, 1'b1,
       {1'b1, 64'h7FFF_FFFF_FFFF_FFFF});
    op("R7 zero << width sat", 64'h0, 16'd8, 2'd0, 2'd0, 1'b0, 1'b1, {1'b0, 64'h0});
    op("R7 one << width sat", 64'h1, 16'd8, 2'd0, 2'd0, 1'b0, 1'b1, {1'b1, 64'h7F});
    op("R7 one << 127 no sat", 64'h1, 16'd127, 2'd1, 2'd1, 1'b0, 1'b0, {1'b0, 64'h0});
  endtask

  task automatic t_s2u_wrap;
    op("R9 s2u negative sat", 64'hFF, 16'd0, 2'd0, 2'd2, 1'b0, 1'b1, {1'b1, 64'h0});
    op("R9 s2u negative no sat", 64'hFF, 16'hFFFF, 2'd0, 2'd2, 1'b0, 1'b0, {1'b0, 64'h7F});
    op("R9 s2u positive overflow", 64'h7F, 16'd1, 2'd0, 2'd2, 1'b0, 1'b1, {1'b0, 64'hFE});
    op("R10 signed wrap", 64'h40, 16'd1, 2'd0, 2'd0, 1'b0, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FF80});
    op("R10 unsigned wrap", 64'hC3, 16'd2, 2'd0, 2'd1, 1'b0, 1'b0, {1'b0, 64'h0C});
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_src = 64'h10; in_cnt = 16'd1; in_wsel = 2'd0; in_mode = 2'd1; in_rnd = 1'b0; in_sat = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_src = 64'h3;
    chk("R11 first result", {out_valid, out_data}, {1'b1, 64'h20});
    chk("R11 ready low when full", {64'd0, in_ready}, 65'd0);
    @(negedge clk);
    chk("R11 held under stall", {out_valid, out_data}, {1'b1, 64'h20});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second result", {out_valid, out_data}, {1'b1, 64'h6});
    @(negedge clk);
    chk("R11 drained", {64'd0, out_valid}, 65'd0);
  endtask

  task automatic t_sticky;
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    chk("R12 cleared", {64'd0, sat_sticky}, 65'd0);
    op("R12 sat event", 64'h40, 16'd1, 2'd0, 2'd0, 1'b0, 1'b1, {1'b1, 64'h7F});
    chk("R12 set", {64'd0, sat_sticky}, 65'd1);
    op("R12 quiet op", 64'h1, 16'd1, 2'd0, 2'd0, 1'b0, 1'b1, {1'b0, 64'h2});
    chk("R12 holds", {64'd0, sat_sticky}, 65'd1);
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    chk("R12 clear", {64'd0, sat_sticky}, 65'd0);
    @(negedge clk);
    sat_clr = 1'b1; in_src = 64'h80; in_cnt = 16'd1; in_wsel = 2'd0; in_mode = 2'd1;
    in_rnd = 1'b0; in_sat = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0; in_valid = 1'b0;
    chk("R12 set wins over clear", {64'd0, sat_sticky}, 65'd1);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] s;
      logic [15:0] c;
      logic [1:0]  ws, md;
      logic        rd, st;
      int          w;
      s  = {$urandom, $urandom};
      ws = 2'($urandom_range(0, 3));
      md = 2'($urandom_range(0, 3));
      rd = 1'($urandom_range(0, 1));
      st = 1'($urandom_range(0, 1));
      w  = 8 << ws;
      if (i % 2 == 0) c = 16'($urandom);
      else begin
        int d;
        d = w + $urandom_range(0, 6) - 3;
        c = (i % 4 == 1) ? 16'(-d) : 16'(d);
      end
      if (i % 8 == 3) s = s & 64'hFF;
      op("R1 R3 R4 R5 R6 R7 R8 R9 R10 sweep", s, c, ws, md, rd, st, model(s, c, ws, md, rd, st));
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_and_width();
    t_round();
    t_full_right();
    t_left_sat();
    t_s2u_wrap();
    t_stall();
    t_sticky();
    t_sweep();
    finish_up();
  end
endmodule